// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns one of several prescaled clock-enable inputs into the baud strobe for a serial channel. Software writes a control register and a fraction register over a simple write port. The control register picks which enable to count, sets an integer divisor N and switches the fractional mode on or off. The fraction register holds a 4-bit value K. In plain mode the block emits one single-cycle strobe every N selected enables. In fractional mode a phase accumulator lengthens some periods by one enable, so the average ratio becomes N + (16-K)/16.

The block also checks the settings. When the divisor is 1 in I/O mode, or when the divisor is 1 with the fraction switched on, or when the fraction is switched on with K = 0, the setting is not supported. In these cases the block divides by plain N and sets a sticky error flag. Every register write restarts the period. Because of this, a change of setting never produces a period that is partly old and partly new.

Top module: `frac_baud_gen`

## Requirements
- R1: `clk_en[i]` is counted only while the clock-select field (control bits 5:4) equals i. Pulses on the other enable lines have no effect on `baud_tick` or on the period count.
- R2: The divisor field (control bits 3:0) sets N. Codes 1 to 15 give N = 1 to 15, and code 0 gives N = 16. With fraction off, every N-th counted enable after a restart produces a strobe.
- R3: Fractional mode is active when control bit 6 = 1, K (fraction register bits 3:0) is 1 to 15 and the divisor is not 1. In this mode, with s = 16-K and period index i counted from 0 after a restart (modulo 16), period i lasts N+1 enables exactly when floor((i+1)s/16) > floor(i·s/16), and N enables otherwise. Any 16 consecutive periods therefore total 16N + 16 - K enables.
- R4: A write with `wr_addr` = 0 loads the control register: bit 6 is the fraction enable, bits 5:4 the clock select and bits 3:0 the divisor. Bit 7 is not stored. A read with `rd_addr` = 0 returns the stored fields and returns 0 in bit 7.
- R5: A write with `wr_addr` = 1 loads K from bits 3:0 and ignores bits 7:4. A read with `rd_addr` = 1 returns K with bits 7:4 at 0.
- R6: After reset, both registers read 0, `baud_tick` is 0 and `cfg_err` is 0.
- R7: After any register write, the next counted enable produces no strobe and restarts both the period count and the fraction phase. The first strobe then comes on the N-th (or N+1-th) counted enable after that one.
- R8: In UART mode (`uart_mode` = 1) with the fraction off and divisor code 1, every counted enable after the restart produces a strobe, and `cfg_err` stays 0.
- R9: Three settings are unsupported: divisor 1 with `uart_mode` = 0, divisor 1 with the fraction enabled, and fraction enabled with K = 0. Each gives plain divide-by-N and sets `cfg_err`. The flag stays set until reset.
- R10: `baud_tick` is high for exactly one clock. It rises on the clock after the edge that samples the enable completing a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 fraction |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read target: 0 control, 1 fraction |
| rd_data | output | 8 | Read data (combinational) |
| clk_en | input | 4 | Prescaled clock enables, one per select code |
| uart_mode | input | 1 | 1 = UART mode, 0 = I/O interface mode |
| baud_tick | output | 1 | Single-cycle baud strobe |
| cfg_err | output | 1 | Sticky unsupported-setting flag |

## Verification
A wrong period counter shows up as a strobe that comes one enable early or late. This is visible at the first strobe after a restart, which is at most 17 counted enables away. A wrong fraction phase moves the long periods to the wrong places. This appears within one group of 16 periods, both in the per-enable strobe pattern and in the total length of the group. A wrong restart or a wrong select shows on the very next counted enable as a strobe where none belongs. A wrong error decode shows on `cfg_err` one clock after the setting takes effect.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
   localparam logic REG_CTRL = 1'b0;
   localparam logic REG_FRAC = 1'b1;
   localparam int   DEF_DATA_W = 8;
   localparam int   DEF_DIV_W  = 4;
   localparam int   DEF_SEL_W  = 2;
   localparam int   DEF_FRAC_W = 4;
endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
   import frac_baud_pkg::*;
#(
   parameter int DATA_W = DEF_DATA_W,
   parameter int DIV_W  = DEF_DIV_W,
   parameter int SEL_W  = DEF_SEL_W,
   parameter int FRAC_W = DEF_FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [DIV_W-1:0]  n_code,
   output logic [SEL_W-1:0]  sel,
   output logic              fe,
   output logic [FRAC_W-1:0] k_val
);
   localparam int FE_BIT = DIV_W + SEL_W;

   logic unused_hi;
   assign unused_hi = ^wr_data[DATA_W-1:FE_BIT+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_code <= '0;
         sel    <= '0;
         fe     <= 1'b0;
         k_val  <= '0;
      end else if (wr_en) begin
         if (wr_addr == REG_CTRL) begin
            {fe, sel, n_code} <= wr_data[FE_BIT:0];
         end else begin
            k_val <= wr_data[FRAC_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == REG_CTRL) begin
         rd_data[FE_BIT:0] = {fe, sel, n_code};
      end else begin
         rd_data[FRAC_W-1:0] = k_val;
      end
   end

   // R4: the top control bit is never stored, so it always reads 0
   a_r4_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == REG_CTRL) |-> (rd_data[DATA_W-1] == 1'b0));
   // R5: bits above K always read 0
   a_r5_frac_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == REG_FRAC) |-> (rd_data[DATA_W-1:FRAC_W] == '0));
   // R4/R5: register contents change only on a write
   a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(n_code) && $stable(sel) && $stable(fe) && $stable(k_val)));
endmodule

// File: rtl/frac_baud_cfg.sv
module frac_baud_cfg
   import frac_baud_pkg::*;
#(
   parameter int DIV_W  = DEF_DIV_W,
   parameter int FRAC_W = DEF_FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  n_code,
   input  logic              fe,
   input  logic [FRAC_W-1:0] k_val,
   input  logic              uart_mode,
   output logic              frac_use,
   output logic              cfg_err
);
   localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

   logic n_is_one;
   logic k_zero;
   logic bad_cfg;

   assign n_is_one = (n_code == DIV_ONE);
   assign k_zero   = (k_val == '0);
   assign bad_cfg  = (n_is_one && (!uart_mode || fe)) || (fe && k_zero);
   assign frac_use = fe && !k_zero && !n_is_one;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_err <= 1'b0;
      end else if (bad_cfg) begin
         cfg_err <= 1'b1;
      end
   end

   // R9: once raised, the flag stays set until reset
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   // R9: a setting that is not supported raises the flag on the next clock
   a_r9_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (fe && k_zero) |=> cfg_err);
endmodule

// File: rtl/frac_baud_core.sv
module frac_baud_core
   import frac_baud_pkg::*;
#(
   parameter int DIV_W   = DEF_DIV_W,
   parameter int FRAC_W  = DEF_FRAC_W,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              te_in,
   input  logic              restart,
   input  logic [DIV_W-1:0]  n_code,
   input  logic              frac_use,
   input  logic [FRAC_W-1:0] k_val,
   output logic              baud_tick
);
   localparam int             CW     = DIV_W + 1;
   localparam logic [CW-1:0]  FULL   = CW'(2 ** DIV_W);
   localparam logic [CW-1:0]  ONE_C  = CW'(1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] len_base;
   logic [CW-1:0] len;
   logic          pend;
   logic          extra;
   logic          period_end;

   assign len_base   = (n_code == '0) ? FULL : {1'b0, n_code};
   assign len        = len_base + CW'(extra);
   assign period_end = te_in && !pend && (cnt == (len - ONE_C));

   generate
      if (FRAC_EN) begin : g_frac
         logic [FRAC_W-1:0] acc;
         logic [FRAC_W-1:0] step;
         logic [FRAC_W-1:0] sum;
         logic              carry;

         assign step         = ~k_val + FRAC_W'(1);
         assign {carry, sum} = {1'b0, acc} + {1'b0, step};
         assign extra        = frac_use & carry;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc <= '0;
            end else if (te_in && pend) begin
               acc <= '0;
            end else if (period_end && frac_use) begin
               acc <= sum;
            end
         end

         // R3: the accumulator never moves while fractional mode is off
         a_r3_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (!frac_use && !(te_in && pend)) |=> $stable(acc));
      end else begin : g_int
         logic unused_frac;
         assign unused_frac = frac_use ^ (^k_val);
         assign extra       = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         pend      <= 1'b0;
         baud_tick <= 1'b0;
      end else begin
         baud_tick <= period_end;
         pend      <= restart | (pend & ~te_in);
         if (te_in) begin
            if (pend || period_end) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + ONE_C;
            end
         end
      end
   end

   // R10: every strobe follows a sampled enable
   a_r10_tick_after_en: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> $past(te_in));
   // R7: the enable that performs a restart never yields a strobe
   a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (te_in && pend) |=> !baud_tick);
   // R2: while no restart is pending, the count stays inside the period
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |-> (cnt < len));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import frac_baud_pkg::*;
#(
   parameter int DATA_W  = DEF_DATA_W,
   parameter int DIV_W   = DEF_DIV_W,
   parameter int SEL_W   = DEF_SEL_W,
   parameter int FRAC_W  = DEF_FRAC_W,
   parameter bit FRAC_EN = 1'b1,
   localparam int NCLK   = 2 ** SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NCLK-1:0]   clk_en,
   input  logic              uart_mode,
   output logic              baud_tick,
   output logic              cfg_err
);
   if (DATA_W < DIV_W + SEL_W + 1) begin : g_bad_data_w
      $error("DATA_W too small for control fields");
   end
   if (FRAC_W > DATA_W || FRAC_W < 1) begin : g_bad_frac_w
      $error("FRAC_W out of range");
   end
   if (DIV_W < 2) begin : g_bad_div_w
      $error("DIV_W must be at least 2");
   end

   logic [DIV_W-1:0]  n_code;
   logic [SEL_W-1:0]  sel;
   logic              fe;
   logic [FRAC_W-1:0] k_val;
   logic              frac_use;
   logic              te_sel;

   assign te_sel = clk_en[sel];

   frac_baud_regs #(
      .DATA_W(DATA_W), .DIV_W(DIV_W), .SEL_W(SEL_W), .FRAC_W(FRAC_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .n_code(n_code), .sel(sel), .fe(fe), .k_val(k_val)
   );

   frac_baud_cfg #(
      .DIV_W(DIV_W), .FRAC_W(FRAC_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .n_code(n_code), .fe(fe), .k_val(k_val),
      .uart_mode(uart_mode), .frac_use(frac_use), .cfg_err(cfg_err)
   );

   frac_baud_core #(
      .DIV_W(DIV_W), .FRAC_W(FRAC_W), .FRAC_EN(FRAC_EN)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .te_in(te_sel), .restart(wr_en),
      .n_code(n_code), .frac_use(frac_use), .k_val(k_val),
      .baud_tick(baud_tick)
   );

   // R10: the strobe lasts one clock unless the selected enable repeats
   a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_tick && !te_sel) |=> !baud_tick);
   // R6: the first clock after reset release shows no strobe and no error
   a_r6_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!baud_tick && !cfg_err));
endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic       wr_addr;
   logic [7:0] wr_data;
   logic       rd_addr;
   logic [7:0] rd_data;
   logic [3:0] clk_en;
   logic       uart_mode;
   logic       baud_tick;
   logic       cfg_err;

   always #5 clk = ~clk;

   frac_baud_gen u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .clk_en(clk_en), .uart_mode(uart_mode), .baud_tick(baud_tick),
      .cfg_err(cfg_err)
   );

   int    total = 0;
   int    bad   = 0;
   int    exp_q[$];
   string tag_q[$];

   // reference state
   int m_n, m_sel, m_fe, m_k;
   int m_cnt, m_pidx;
   bit m_pend;

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic bit long_period(int idx, int s);
      return (((idx + 1) * s) / 16) > ((idx * s) / 16);
   endfunction

   function automatic int model(int idx);
      int dn, len;
      bit fuse;
      if (idx != m_sel) return 0;
      if (m_pend) begin
         m_pend = 0; m_cnt = 0; m_pidx = 0;
         return 0;
      end
      dn   = (m_n == 0) ? 16 : m_n;
      fuse = (m_fe != 0) && (m_k != 0) && (m_n != 1);
      len  = dn + ((fuse && long_period(m_pidx, 16 - m_k)) ? 1 : 0);
      m_cnt++;
      if (m_cnt == len) begin
         m_cnt  = 0;
         m_pidx = (m_pidx + 1) % 16;
         return 1;
      end
      return 0;
   endfunction

   // scoreboard monitor: one expected item per enable pulse
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         int    e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, int'(baud_tick), e);
      end
   end

   task automatic pulse(int idx, string tag);
      @(negedge clk);
      clk_en = 4'b0001 << idx;
      exp_q.push_back(model(idx));
      tag_q.push_back(tag);
      @(negedge clk);
      clk_en = 4'b0000;
   endtask

   task automatic wr(bit a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a == 1'b0) begin
         m_n = int'(d[3:0]); m_sel = int'(d[5:4]); m_fe = int'(d[6]);
      end else begin
         m_k = int'(d[3:0]);
      end
      m_pend = 1;
   endtask

   task automatic rdchk(bit a, int exp, string tag);
      @(negedge clk);
      rd_addr = a;
      #1;
      chk(tag, int'(rd_data), exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; clk_en = '0; wr_en = 1'b0; wr_addr = 1'b0;
      wr_data = '0; rd_addr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_n = 0; m_sel = 0; m_fe = 0; m_k = 0;
      m_cnt = 0; m_pidx = 0; m_pend = 0;
   endtask

   task automatic frac_run(string tag, int exp_len);
      int ticks = 0;
      int pulses = 0;
      while (ticks < 16 && pulses < 400) begin
         pulse(0, tag);
         pulses++;
         if (baud_tick) ticks++;
      end
      chk({tag, " group length"}, pulses - 1, exp_len);
   endtask

   initial begin
      #2000000;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      uart_mode = 1'b1;
      do_reset();
      // R6: reset state
      @(negedge clk);
      chk("R6 tick", int'(baud_tick), 0);
      chk("R6 err", int'(cfg_err), 0);
      rdchk(1'b0, 0, "R6 ctrl read");
      rdchk(1'b1, 0, "R6 frac read");

      // R5 and R4: field layout and ignored bits
      wr(1'b1, 8'hF3);
      rdchk(1'b1, 8'h03, "R5 frac upper ignored");
      wr(1'b0, 8'hFF);
      rdchk(1'b0, 8'h7F, "R4 ctrl top bit ignored");
      wr(1'b0, 8'h25);
      rdchk(1'b0, 8'h25, "R4 ctrl fields");

      // R1/R2: select 1, N = 3, noise on the other lines
      wr(1'b0, 8'h13);
      for (int i = 0; i < 10; i++) begin
         pulse(1, "R1 R2 selected N=3");
         pulse(0, "R1 unselected line 0");
         pulse(3, "R1 unselected line 3");
      end

      // R2: code 0 means 16, select 3
      wr(1'b0, 8'h30);
      for (int i = 0; i < 34; i++) pulse(3, "R2 N=16");

      // R7: mid-period rewrite restarts the count
      wr(1'b0, 8'h04);
      for (int i = 0; i < 3; i++) pulse(0, "R7 before rewrite");
      wr(1'b0, 8'h04);
      for (int i = 0; i < 6; i++) pulse(0, "R7 after rewrite");

      // R3: fractional groups, K = 4 with N = 5, then K = 13 with N = 2
      wr(1'b1, 8'h04);
      wr(1'b0, 8'h45);
      frac_run("R3 K=4 N=5", 16 * 5 + 12);
      wr(1'b1, 8'h0D);
      wr(1'b0, 8'h42);
      frac_run("R3 K=13 N=2", 16 * 2 + 3);
      repeat (3) @(negedge clk);
      chk("R3 no error", int'(cfg_err), 0);

      // R8: divide by 1 in UART mode
      wr(1'b0, 8'h01);
      for (int i = 0; i < 6; i++) pulse(0, "R8 N=1 uart");
      repeat (2) @(negedge clk);
      chk("R8 no error", int'(cfg_err), 0);

      // R9: divide by 1 in I/O mode, then sticky
      uart_mode = 1'b0;
      wr(1'b0, 8'h01);
      for (int i = 0; i < 5; i++) pulse(0, "R9 io N=1 fallback");
      repeat (2) @(negedge clk);
      chk("R9 io N=1 err", int'(cfg_err), 1);
      uart_mode = 1'b1;
      wr(1'b0, 8'h03);
      repeat (3) @(negedge clk);
      chk("R9 err sticky", int'(cfg_err), 1);

      // R9: fraction enabled with K = 0
      do_reset();
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h43);
      for (int i = 0; i < 7; i++) pulse(0, "R9 K=0 fallback");
      chk("R9 K=0 err", int'(cfg_err), 1);

      // R9: fraction enabled with N = 1 in UART mode
      do_reset();
      wr(1'b1, 8'h05);
      wr(1'b0, 8'h41);
      for (int i = 0; i < 4; i++) pulse(0, "R9 N=1 frac fallback");
      chk("R9 N=1 frac err", int'(cfg_err), 1);

      repeat (4) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule